// File: doc/BRIEF.md
# Residual Add and Clip Row Unit

This block is the last step of an 8x8 inverse-transform reconstruction path. Each accepted beat carries one row of eight signed 16-bit reconstructed residuals and the eight unsigned 8-bit prediction pixels of the same row. In every lane the residual is scaled down by 32 with round-half-up, added to its prediction pixel, and clamped to the 8-bit pixel range.

The result row leaves through a registered output stage with a valid/ready handshake. An internal row counter walks through the eight rows of a block. It tags each output row with its index and with the write address `base + row * stride`. That address is the same one the prediction row was read from, so the reconstruction overwrites the prediction in place. After the last row of a block has been handed off, the block raises a single-cycle completion pulse.

Top module: `recon_add_clip`

## Requirements
- R1: Each lane's residual `r` (signed, 16 bits, lane k at input bits [16k+15:16k]) is scaled to `floor((r + 16) / 32)`. The scaling is computed without intermediate wrap, so r = 32767 scales to 1024 and r = -32768 scales to -1024.
- R2: The scaled residual is added to the zero-extended prediction pixel (lane k at bits [8k+7:8k]). A sum in 0..255 is output unchanged.
- R3: A negative sum is output as 0.
- R4: A sum above 255 is output as 255.
- R5: Output lane k appears at `out_pix[8k+7:8k]`, computed only from input lane k.
- R6: A row accepted on a clock edge (`in_valid && in_ready`) is presented on `out_valid`/`out_pix` right after that edge.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output row, address and index hold unchanged.
- R8: The n-th row accepted since reset (counting from 0) carries `out_row = n mod 8` and `out_addr = (blk_base + out_row * row_stride) mod 2^16`. Base and stride are sampled when the row is accepted.
- R9: `blk_done` is high for exactly one cycle. It rises in the cycle after the handshake of an output row whose `out_row` is 7.
- R10: During and right after reset, `out_valid` and `blk_done` are 0 and `in_ready` is 1. The first row accepted afterwards is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_base | input | 16 | Block base address |
| row_stride | input | 16 | Address step between rows |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Input row can be accepted |
| in_resid | input | 128 | Eight signed 16-bit residuals |
| in_pred | input | 64 | Eight unsigned 8-bit prediction pixels |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Downstream accepts output row |
| out_pix | output | 64 | Eight reconstructed 8-bit pixels |
| out_addr | output | 16 | Write-back address of the output row |
| out_row | output | 3 | Row index within the block |
| blk_done | output | 1 | One-cycle pulse after row 7 is handed off |

## Verification
Two functions can fall in the same clock edge. One is the hand-off of row 7, which schedules the completion pulse. The other is the acceptance of row 0 of the next block, which refills the output register. When `out_ready` stays high and input is continuous, both happen on one edge. The bench provokes this with long back-to-back runs and also with random stalls on both sides. A behavioural model predicts, edge by edge, the pulse, the new row's contents and address, and the refilled valid flag. Every cycle the bench compares all of these, so a pulse that is lost or doubled, or a row dropped at the wrap, shows up at once.

// File: rtl/rac_pkg.sv
`timescale 1ns/1ps
package rac_pkg;
  localparam int LANES  = 8;
  localparam int RES_W  = 16;
  localparam int PIX_W  = 8;
  localparam int SHIFT  = 5;
  localparam int ROWS   = 8;
  localparam int ADDR_W = 16;
endpackage

// File: rtl/rac_lane.sv
`timescale 1ns/1ps
module rac_lane #(
  parameter int RES_W = 16,
  parameter int PIX_W = 8,
  parameter int SHIFT = 5
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [PIX_W-1:0] pred_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int EXT_W = RES_W + 1;
  localparam logic signed [EXT_W-1:0] RND_C = EXT_W'(1) <<< (SHIFT - 1);

  logic signed [EXT_W-1:0] res_ext;
  logic signed [EXT_W-1:0] biased;
  logic signed [EXT_W-1:0] scaled;
  logic signed [EXT_W-1:0] pred_ext;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    res_ext  = $signed({res_i[RES_W-1], res_i});
    biased   = res_ext + RND_C;
    scaled   = biased >>> SHIFT;
    pred_ext = $signed({{(EXT_W-PIX_W){1'b0}}, pred_i});
    sum      = scaled + pred_ext;
    if (sum[EXT_W-1]) begin
      pix_o = '0;
    end else if (|sum[EXT_W-2:PIX_W]) begin
      pix_o = '1;
    end else begin
      pix_o = sum[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/rac_row_dp.sv
`timescale 1ns/1ps
module rac_row_dp #(
  parameter int LANES = 8,
  parameter int RES_W = 16,
  parameter int PIX_W = 8,
  parameter int SHIFT = 5
) (
  input  logic [LANES*RES_W-1:0] resid_i,
  input  logic [LANES*PIX_W-1:0] pred_i,
  output logic [LANES*PIX_W-1:0] pix_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rac_lane #(
      .RES_W (RES_W),
      .PIX_W (PIX_W),
      .SHIFT (SHIFT)
    ) u_lane (
      .res_i  (resid_i[k*RES_W +: RES_W]),
      .pred_i (pred_i[k*PIX_W +: PIX_W]),
      .pix_o  (pix_o[k*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/rac_row_seq.sv
`timescale 1ns/1ps
module rac_row_seq #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              drain_i,
  input  logic [ROW_W-1:0]  drain_row_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic             done_q, done_d;

  always_comb begin
    row_d = row_q;
    if (acc_i) begin
      row_d = (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
    end
    done_d = drain_i && (drain_row_i == LAST_ROW);
    addr_o = base_i + ADDR_W'(row_q) * stride_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (acc_i) row_q <= row_d;
      done_q <= done_d;
    end
  end

  assign row_o  = row_q;
  assign done_o = done_q;

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && row_q != LAST_ROW) |=> row_q == $past(row_q) + ROW_W'(1));
  // R8
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && row_q == LAST_ROW) |=> row_q == '0);
  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_i && drain_row_i == LAST_ROW) |=> done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/rac_out_stage.sv
`timescale 1ns/1ps
module rac_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid_i,
  output logic          up_ready_o,
  input  logic [DW-1:0] up_data_i,
  output logic          dn_valid_o,
  input  logic          dn_ready_i,
  output logic [DW-1:0] dn_data_o
);
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q;
  logic          load_en;

  always_comb begin
    up_ready_o = !vld_q || dn_ready_i;
    load_en    = up_valid_i && up_ready_o;
    vld_d      = vld_q;
    if (load_en) begin
      vld_d = 1'b1;
    end else if (dn_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= up_data_i;
  end

  assign dn_valid_o = vld_q;
  assign dn_data_o  = dat_q;

  // R6
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_i && up_ready_o) |=> dn_valid_o);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_data_o)));
  // R7
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid_o && dn_ready_i && !up_valid_i) |=> !dn_valid_o);
endmodule

// File: rtl/recon_add_clip.sv
`timescale 1ns/1ps
module recon_add_clip
  import rac_pkg::*;
#(
  parameter int P_LANES  = LANES,
  parameter int P_RES_W  = RES_W,
  parameter int P_PIX_W  = PIX_W,
  parameter int P_SHIFT  = SHIFT,
  parameter int P_ROWS   = ROWS,
  parameter int P_ADDR_W = ADDR_W,
  localparam int ROW_W   = (P_ROWS > 1) ? $clog2(P_ROWS) : 1,
  localparam int PIXROW_W = P_LANES * P_PIX_W,
  localparam int DW      = ROW_W + P_ADDR_W + PIXROW_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [P_ADDR_W-1:0]         blk_base,
  input  logic [P_ADDR_W-1:0]         row_stride,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [P_LANES*P_RES_W-1:0]  in_resid,
  input  logic [PIXROW_W-1:0]         in_pred,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [PIXROW_W-1:0]         out_pix,
  output logic [P_ADDR_W-1:0]         out_addr,
  output logic [ROW_W-1:0]            out_row,
  output logic                        blk_done
);
  logic [PIXROW_W-1:0] pix_c;
  logic [ROW_W-1:0]    row_c;
  logic [P_ADDR_W-1:0] addr_c;
  logic [DW-1:0]       st_in, st_out;
  logic                acc, drain;

  rac_row_dp #(
    .LANES (P_LANES),
    .RES_W (P_RES_W),
    .PIX_W (P_PIX_W),
    .SHIFT (P_SHIFT)
  ) u_dp (
    .resid_i (in_resid),
    .pred_i  (in_pred),
    .pix_o   (pix_c)
  );

  assign acc   = in_valid && in_ready;
  assign drain = out_valid && out_ready;
  assign st_in = {row_c, addr_c, pix_c};

  rac_row_seq #(
    .ROWS   (P_ROWS),
    .ADDR_W (P_ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (acc),
    .base_i      (blk_base),
    .stride_i    (row_stride),
    .drain_i     (drain),
    .drain_row_i (out_row),
    .row_o       (row_c),
    .addr_o      (addr_c),
    .done_o      (blk_done)
  );

  rac_out_stage #(
    .DW (DW)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid_i (in_valid),
    .up_ready_o (in_ready),
    .up_data_i  (st_in),
    .dn_valid_o (out_valid),
    .dn_ready_i (out_ready),
    .dn_data_o  (st_out)
  );

  assign {out_row, out_addr, out_pix} = st_out;

  // R7
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

// File: tb/recon_add_clip_bench.sv
`timescale 1ns/1ps
module recon_add_clip_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  blk_base, row_stride;
  logic         in_valid, in_ready;
  logic [127:0] in_resid;
  logic [63:0]  in_pred;
  logic         out_valid, out_ready;
  logic [63:0]  out_pix;
  logic [15:0]  out_addr;
  logic [2:0]   out_row;
  logic         blk_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  recon_add_clip u_recon_add_clip (
    .clk(clk), .rst_n(rst_n), .blk_base(blk_base), .row_stride(row_stride),
    .in_valid(in_valid), .in_ready(in_ready), .in_resid(in_resid),
    .in_pred(in_pred), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_addr(out_addr), .out_row(out_row),
    .blk_done(blk_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_pix(input logic [15:0] r, input logic [7:0] p);
    int t;
    t = (int'($signed(r)) + 16) >>> 5;
    t = t + int'(p);
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  function automatic logic [63:0] ref_row(input logic [127:0] r, input logic [63:0] p);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'(ref_pix(r[k*16 +: 16], p[k*8 +: 8]));
    return v;
  endfunction

  // model state
  bit          m_valid, m_done;
  logic [63:0] m_pix;
  logic [15:0] m_addr;
  int          m_row, m_cnt;
  bit          first_seen;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; out_ready = 0; in_resid = '0; in_pred = '0;
    blk_base = 16'h1000; row_stride = 16'h0040;
    m_valid = 0; m_done = 0; m_pix = '0; m_addr = '0; m_row = 0; m_cnt = 0;
    first_seen = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R10 out_valid in reset", 64'(out_valid), 0);
    chk(blk_done === 1'b0, "R10 blk_done in reset", 64'(blk_done), 0);
    chk(in_ready === 1'b1, "R10 in_ready in reset", 64'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      // compare registered outputs with the model
      chk(out_valid === m_valid, "R6 R7 out_valid", 64'(out_valid), 64'(m_valid));
      chk(blk_done === m_done, "R9 blk_done", 64'(blk_done), 64'(m_done));
      if (m_valid) begin
        chk(out_pix === m_pix, "R1 R2 R3 R4 R5 out_pix", out_pix, m_pix);
        chk(out_addr === m_addr, "R8 out_addr", 64'(out_addr), 64'(m_addr));
        chk(out_row === 3'(m_row), "R8 R10 out_row", 64'(out_row), 64'(m_row));
        if (!first_seen) begin
          first_seen = 1;
          // R1 R3 R4 fixed row: see stimulus at cyc 0
          chk(out_pix === 64'hfffd00ff0a090001, "R1 R3 R4 directed row",
              out_pix, 64'hfffd00ff0a090001);
          chk(out_row === 3'd0, "R10 first row index", 64'(out_row), 0);
        end
      end
      // drive stimulus
      if (cyc % 50 == 49) begin
        blk_base = 16'($urandom); row_stride = 16'($urandom_range(1, 4096));
      end
      if (cyc == 0) begin
        in_valid = 1; out_ready = 1;
        in_resid = {16'sd8200, 16'sd8000, -16'sd32768, 16'sd32767,
                    -16'sd16, -16'sd17, 16'sd15, 16'sd16};
        in_pred  = {8'd100, 8'd3, 8'd255, 8'd0, 8'd10, 8'd10, 8'd0, 8'd0};
      end else begin
        in_valid  = (cyc < 300) ? 1'b1 : ($urandom_range(0, 9) < 8);
        out_ready = (cyc < 200) ? 1'b1 : ($urandom_range(0, 9) < 7);
        for (int k = 0; k < 8; k++) begin
          if ($urandom_range(0, 3) == 0) in_resid[k*16 +: 16] = 16'($urandom);
          else in_resid[k*16 +: 16] = 16'($urandom_range(0, 16000) - 8000);
        end
        in_pred = {$urandom, $urandom};
      end
      #1;
      chk(in_ready === (!m_valid || out_ready), "R7 in_ready",
          64'(in_ready), 64'(!m_valid || out_ready));
      // advance the model across the coming edge
      begin
        bit fo, fi;
        fo = m_valid && out_ready;
        fi = in_valid && (!m_valid || out_ready);
        m_done = fo && (m_row == 7);
        if (fi) begin
          m_valid = 1;
          m_pix   = ref_row(in_resid, in_pred);
          m_addr  = 16'(int'(blk_base) + m_cnt * int'(row_stride));
          m_row   = m_cnt;
          m_cnt   = (m_cnt + 1) % 8;
        end else if (fo) begin
          m_valid = 0;
        end
      end
    end
    summary();
  end
endmodule